// File: doc/BRIEF.md
# Integer ALU with Signed-Direction Shifts

This block is the combinational integer execution unit of a small RISC core. Each cycle it receives a 6-bit opcode, a first operand, a register second operand and a 16-bit immediate field. The opcode selects where the second operand comes from: the register value, the immediate sign-extended, or the immediate zero-extended. The block then returns a 32-bit result.

The operation set covers addition, subtraction, low-word multiply, three-way compare, the four bitwise operations and two shifts. The bitwise operations are or, and, xor, and a bit-clear that masks the first operand with the inverted second. For both shifts the sign of one shift amount chooses the direction. A bound check raises a trap flag when the first operand lies outside the range from zero up to, but not including, the second operand.

Division and modulo opcodes are recognised but not computed. These, and every opcode that does not belong to this unit, raise an unsupported flag so that surrounding logic can route the instruction elsewhere.

Top module: `alu_core_bidir`

## Requirements
- R1: Register-form opcodes take the second operand from `src_b`. The opcodes are: 0 add, 1 subtract, 2 multiply, 5 compare, 8 or, 9 and, 10 bit-clear, 11 xor, 12 logical shift, 13 arithmetic shift, 14 bound check.
- R2: Opcodes 16 to 30 perform the same operation as (opcode - 16). Their second operand is `imm` sign-extended from bit 15.
- R3: The unsigned-immediate opcodes use `imm` zero-extended as the second operand. Opcodes 54 to 59 are add, subtract, multiply, divide, modulo and compare. Opcodes 60 to 63 are or, and, bit-clear and xor. Opcode 39 is the bound check.
- R4: Add, subtract and multiply return the low 32 bits of the exact result, with wrap-around.
- R5: Or, and and xor give the usual bitwise result. Bit-clear gives `first & ~second`.
- R6: Compare returns 32'hFFFFFFFF when first < second as signed integers, 0 when they are equal, and 1 when first > second. The comparison uses the exact signed values, so no overflow affects it.
- R7: For the logical shift, the second operand is a signed amount. An amount above zero shifts left. Zero or a negative amount shifts right with zero fill by the magnitude of the amount. A magnitude of 32 or more gives 0, and this includes the amount -2^31.
- R8: The arithmetic shift matches the logical shift, except that a right shift fills with copies of bit 31. A right magnitude of 32 or more gives 32 copies of bit 31.
- R9: For the bound-check opcodes (14, 30, 39), `chk_fail` is 1 exactly when the first operand is outside the signed range 0 <= first < second, and `result` is 0. For every other opcode, `chk_fail` is 0.
- R10: `unsupported` is 1 for the division and modulo opcodes (3, 4, 19, 20, 57, 58) and for every opcode not listed in R1 to R3. Those undefined opcodes are 6, 7, 15, 22, 23, 31, 32 to 38 and 40 to 53. While `unsupported` is 1, `result` is 0 and `chk_fail` is 0. For all other opcodes, `unsupported` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Operation and operand-source select |
| src_a | input | 32 | First operand; value under test for a bound check |
| src_b | input | 32 | Register second operand |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| chk_fail | output | 1 | Bound check failed |
| unsupported | output | 1 | Opcode not executed by this unit |

## Verification
The bench targets the shift-amount edges: 0, +1, -1, +31, -31, +32, -32 and -2^31. A unit that treats zero as a left shift is still correct here, because both directions leave the value unchanged. A unit that negates -2^31 naively, or uses only the low five amount bits, returns a shifted copy where 0 or sign fill is expected. Compare is driven with operands whose wrapped difference has the wrong sign, such as the most negative value against 1; a subtract-and-take-sign design reports +1 there. The bound check is exercised with a negative value, with the value equal to the bound, and with a bound of zero, where an unsigned compare or an inclusive limit gives the wrong flag. A sweep over all 64 opcodes catches any opcode mapped to the wrong operation, the wrong immediate extension, or a missing unsupported flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    FN_ADD   = 4'd0,
    FN_SUB   = 4'd1,
    FN_MUL   = 4'd2,
    FN_DIV   = 4'd3,
    FN_MOD   = 4'd4,
    FN_CMP   = 4'd5,
    FN_RSV6  = 4'd6,
    FN_RSV7  = 4'd7,
    FN_OR    = 4'd8,
    FN_AND   = 4'd9,
    FN_BIC   = 4'd10,
    FN_XOR   = 4'd11,
    FN_LSH   = 4'd12,
    FN_ASH   = 4'd13,
    FN_CHK   = 4'd14,
    FN_RSV15 = 4'd15
  } alu_fn_e;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_SIMM = 2'd1,
    SRC_UIMM = 2'd2
  } opb_src_e;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output alu_fn_e          fn,
  output opb_src_e         src,
  output logic             unsupported
);

  logic       legal;
  logic [3:0] low;

  always_comb begin
    fn    = FN_ADD;
    src   = SRC_REG;
    legal = 1'b0;
    low   = opcode[3:0];
    if (opcode[5] == 1'b0) begin
      // register form (0..15) and signed-immediate form (16..31)
      fn    = alu_fn_e'(low);
      src   = opcode[4] ? SRC_SIMM : SRC_REG;
      legal = !(low inside {4'd6, 4'd7, 4'd15});
    end else if (opcode == 6'd39) begin
      fn    = FN_CHK;
      src   = SRC_UIMM;
      legal = 1'b1;
    end else if (opcode >= 6'd54) begin
      src   = SRC_UIMM;
      legal = 1'b1;
      if (opcode <= 6'd59) fn = alu_fn_e'(4'(opcode - 6'd54));
      else                 fn = alu_fn_e'(4'(opcode - 6'd52));
    end
    unsupported = !legal || (fn inside {FN_DIV, FN_MOD});
  end

endmodule

// File: rtl/alu_operand.sv
module alu_operand
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  opb_src_e          src,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opb
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] simm_val;
  logic [DATA_W-1:0] uimm_val;

  generate
    if (EXT_W > 0) begin : g_extend
      assign simm_val = {{EXT_W{imm[IMM_W-1]}}, imm};
      assign uimm_val = {{EXT_W{1'b0}}, imm};
    end else begin : g_trunc
      assign simm_val = imm[DATA_W-1:0];
      assign uimm_val = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_SIMM: opb = simm_val;
      SRC_UIMM: opb = uimm_val;
      default:  opb = reg_val;
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] amt,
  input  logic              arith,
  output logic [DATA_W-1:0] out
);

  localparam int SHW = $clog2(DATA_W);

  logic              go_left;
  logic [DATA_W-1:0] mag;
  logic              far;
  logic [SHW-1:0]    sh;
  logic              fill;

  always_comb begin
    go_left = !amt[DATA_W-1] && (amt != '0);
    mag     = go_left ? amt : (~amt + 1'b1);
    far     = |mag[DATA_W-1:SHW];
    sh      = mag[SHW-1:0];
    fill    = arith & val[DATA_W-1];
    if (go_left) begin
      out = far ? '0 : (val << sh);
    end else if (far) begin
      out = {DATA_W{fill}};
    end else if (arith) begin
      out = $unsigned($signed(val) >>> sh);
    end else begin
      out = val >> sh;
    end
  end

  always_comb begin
    if (amt == '0) AST_SHIFT_ZERO_KEEPS: assert (out == val); // R7
    if (!arith && !go_left && amt != '0)
      AST_LOGIC_RIGHT_CLEARS_MSB: assert (!out[DATA_W-1]); // R7
    if (arith && !go_left)
      AST_ARITH_RIGHT_SIGN: assert (out[DATA_W-1] == val[DATA_W-1]); // R8
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              bound_bad
);

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] cmp_val;
  logic              a_lt_b;

  always_comb begin
    sum     = a + b;
    diff    = a - b;
    prod    = a * b;
    a_lt_b  = $signed(a) < $signed(b);
    if (a_lt_b)      cmp_val = '1;
    else if (a == b) cmp_val = '0;
    else             cmp_val = DATA_W'(1);
    bound_bad = a[DATA_W-1] || !a_lt_b;
    unique case (fn)
      FN_SUB:  res = diff;
      FN_MUL:  res = prod;
      FN_CMP:  res = cmp_val;
      default: res = sum;
    endcase
  end

endmodule

// File: rtl/alu_core_bidir.sv
module alu_core_bidir
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              chk_fail,
  output logic              unsupported
);

  alu_fn_e           fn;
  opb_src_e          src;
  logic              unsup_d;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] arith_res;
  logic              bound_bad;
  logic [DATA_W-1:0] shift_res;

  alu_decode u_decode (
    .opcode      (opcode),
    .fn          (fn),
    .src         (src),
    .unsupported (unsup_d)
  );

  alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
    .src     (src),
    .reg_val (src_b),
    .imm     (imm),
    .opb     (opb)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .fn        (fn),
    .a         (src_a),
    .b         (opb),
    .res       (arith_res),
    .bound_bad (bound_bad)
  );

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .val   (src_a),
    .amt   (opb),
    .arith (fn == FN_ASH),
    .out   (shift_res)
  );

  always_comb begin
    result      = '0;
    chk_fail    = 1'b0;
    unsupported = unsup_d;
    if (!unsup_d) begin
      unique case (fn)
        FN_ADD, FN_SUB, FN_MUL, FN_CMP: result = arith_res;
        FN_OR:   result = src_a | opb;
        FN_AND:  result = src_a & opb;
        FN_BIC:  result = src_a & ~opb;
        FN_XOR:  result = src_a ^ opb;
        FN_LSH, FN_ASH: result = shift_res;
        FN_CHK:  chk_fail = bound_bad;
        default: result = '0;
      endcase
    end
  end

  always_comb begin
    if (unsupported) AST_UNSUP_QUIET: assert (result == '0 && !chk_fail); // R10
    if (!unsupported && fn == FN_CMP)
      AST_CMP_TRISTATE: assert (result == '0 || result == '1 || result == DATA_W'(1)); // R6
    if (!unsupported && fn == FN_BIC)
      AST_BIC_DISJOINT: assert ((result & opb) == '0); // R5
    if (!unsupported && fn == FN_CHK && !chk_fail)
      AST_CHK_PASS_NONNEG: assert (!src_a[DATA_W-1]); // R9
    if (chk_fail) AST_CHK_ONLY_ON_CHECK: assert (fn == FN_CHK); // R9
  end

endmodule

// File: tb/alu_core_bidir_tb_top.sv
module alu_core_bidir_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [5:0]  opcode;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [15:0] imm;
  logic [31:0] result;
  logic        chk_fail;
  logic        unsupported;

  int n_checks = 0;
  int n_fail   = 0;
  bit drv_done = 0;

  typedef struct {
    logic [5:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [31:0] e_res;
    logic        e_chk;
    logic        e_uns;
    string       tag;
  } item_t;

  item_t sb_q[$];

  alu_core_bidir dut_i (
    .opcode      (opcode),
    .src_a       (src_a),
    .src_b       (src_b),
    .imm         (imm),
    .result      (result),
    .chk_fail    (chk_fail),
    .unsupported (unsupported)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference shift: signed amount, positive = left
  function automatic logic [31:0] ref_shift(logic [31:0] v, logic [31:0] amt, bit ar);
    longint s;
    longint m;
    logic [31:0] r;
    s = longint'($signed(amt));
    if (s > 0) begin
      if (s >= 32) r = 0; else r = v << s;
    end else begin
      m = -s;
      if (m >= 32) r = (ar && v[31]) ? 32'hFFFF_FFFF : 32'h0;
      else if (ar) r = 32'($signed(v) >>> m);
      else r = v >> m;
    end
    return r;
  endfunction

  task automatic drive(logic [5:0] op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] im, string tag);
    item_t it;
    int kind;
    logic [31:0] sec;
    longint sa;
    longint sb;
    kind = -1;
    sec  = b;
    if (op <= 6'd14 && !(op inside {6'd6, 6'd7})) kind = int'(op);
    else if (op >= 6'd16 && op <= 6'd30 && !(op inside {6'd22, 6'd23})) begin
      kind = int'(op) - 16; sec = {{16{im[15]}}, im};
    end else if (op == 6'd39) begin
      kind = 14; sec = {16'h0, im};
    end else if (op >= 6'd54 && op <= 6'd59) begin
      kind = int'(op) - 54; sec = {16'h0, im};
    end else if (op >= 6'd60) begin
      kind = int'(op) - 52; sec = {16'h0, im};
    end
    it.op = op; it.a = a; it.b = b; it.im = im; it.tag = tag;
    it.e_res = 0; it.e_chk = 0; it.e_uns = 0;
    sa = longint'($signed(a));
    sb = longint'($signed(sec));
    case (kind)
      0:  it.e_res = a + sec;
      1:  it.e_res = a - sec;
      2:  it.e_res = 32'(longint'(a) * longint'(sec));
      5:  it.e_res = (sa < sb) ? 32'hFFFF_FFFF : ((sa == sb) ? 32'h0 : 32'h1);
      8:  it.e_res = a | sec;
      9:  it.e_res = a & sec;
      10: it.e_res = a & ~sec;
      11: it.e_res = a ^ sec;
      12: it.e_res = ref_shift(a, sec, 1'b0);
      13: it.e_res = ref_shift(a, sec, 1'b1);
      14: it.e_chk = !(sa >= 0 && sa < sb);
      default: it.e_uns = 1;
    endcase
    @(posedge clk);
    #1;
    opcode = op; src_a = a; src_b = b; imm = im;
    sb_q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_checks++;
        if (result !== it.e_res || chk_fail !== it.e_chk || unsupported !== it.e_uns) begin
          n_fail++;
          $display("FAIL %s op=%0d a=%h b=%h imm=%h: got res=%h chk=%b uns=%b exp res=%h chk=%b uns=%b",
                   it.tag, it.op, it.a, it.b, it.im, result, chk_fail, unsupported,
                   it.e_res, it.e_chk, it.e_uns);
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (!drv_done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!drv_done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    opcode = 0; src_a = 0; src_b = 0; imm = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // reset/idle state: all-zero inputs select add of zeros (R1)
    drive(6'd0, 32'h0, 32'h0, 16'h0, "R1 idle");
    // R1 register forms
    drive(6'd0, 32'd7, 32'd5, 16'hFFFF, "R1 add reg");
    drive(6'd14, 32'd3, 32'd4, 16'h0, "R1 chk reg");
    // R2 signed immediate
    drive(6'd16, 32'd10, 32'h0, 16'hFFFE, "R2 addi negative imm");
    drive(6'd27, 32'h0000_00FF, 32'h0, 16'h8001, "R2 xori sign-extended");
    // R3 unsigned immediate
    drive(6'd54, 32'd10, 32'h0, 16'hFFFE, "R3 addiu zero-extended");
    drive(6'd62, 32'hFFFF_FFFF, 32'h0, 16'h00F0, "R3 biciu");
    drive(6'd59, 32'd5, 32'h0, 16'h8000, "R3 cmpiu vs 32768");
    // R4 wrap
    drive(6'd0, 32'hFFFF_FFFF, 32'd2, 16'h0, "R4 add wrap");
    drive(6'd1, 32'd0, 32'd1, 16'h0, "R4 sub wrap");
    drive(6'd2, 32'h0001_0001, 32'h0001_0001, 16'h0, "R4 mul low word");
    drive(6'd2, 32'hFFFF_FFFD, 32'd7, 16'h0, "R4 mul negative");
    // R5 bitwise
    drive(6'd10, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, "R5 bic");
    drive(6'd9, 32'h1234_5678, 32'h0F0F_0F0F, 16'h0, "R5 and");
    // R6 compare corners
    drive(6'd5, 32'h8000_0000, 32'd1, 16'h0, "R6 cmp minint vs 1");
    drive(6'd5, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, "R6 cmp maxint vs -1");
    drive(6'd5, 32'd42, 32'd42, 16'h0, "R6 cmp equal");
    // R7 logical shift amounts
    drive(6'd12, 32'h8000_0001, 32'd0, 16'h0, "R7 lsh by 0");
    drive(6'd12, 32'h8000_0001, 32'd1, 16'h0, "R7 lsh left 1");
    drive(6'd12, 32'h8000_0001, 32'hFFFF_FFFF, 16'h0, "R7 lsh right 1");
    drive(6'd12, 32'h8000_0001, 32'd31, 16'h0, "R7 lsh left 31");
    drive(6'd12, 32'h8000_0001, 32'hFFFF_FFE1, 16'h0, "R7 lsh right 31");
    drive(6'd12, 32'hFFFF_FFFF, 32'd32, 16'h0, "R7 lsh left 32");
    drive(6'd12, 32'hFFFF_FFFF, 32'hFFFF_FFE0, 16'h0, "R7 lsh right 32");
    drive(6'd12, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, "R7 lsh minint amount");
    drive(6'd28, 32'h0000_0F00, 32'h0, 16'hFFFC, "R7 lshi right 4");
    // R8 arithmetic shift
    drive(6'd13, 32'h8000_0000, 32'hFFFF_FFFC, 16'h0, "R8 ash right 4 neg");
    drive(6'd13, 32'h8000_0000, 32'hFFFF_FFC0, 16'h0, "R8 ash right 64 neg");
    drive(6'd13, 32'h7000_0000, 32'hFFFF_FFE0, 16'h0, "R8 ash right 32 pos");
    drive(6'd13, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, "R8 ash minint amount");
    drive(6'd13, 32'h8000_0001, 32'd40, 16'h0, "R8 ash left 40");
    drive(6'd29, 32'h8000_0000, 32'h0, 16'hFFFF, "R8 ashi right 1");
    // R9 bound check
    drive(6'd14, 32'hFFFF_FFFF, 32'd10, 16'h0, "R9 chk negative");
    drive(6'd14, 32'd10, 32'd10, 16'h0, "R9 chk at bound");
    drive(6'd14, 32'd0, 32'd0, 16'h0, "R9 chk zero bound");
    drive(6'd14, 32'd0, 32'd1, 16'h0, "R9 chk zero in range");
    drive(6'd30, 32'd5, 32'd100, 16'hFFFF, "R9 chki negative bound");
    drive(6'd39, 32'd40000, 32'd0, 16'hFFFF, "R9 chkiu big bound");
    // R10 unsupported
    drive(6'd3, 32'd9, 32'd3, 16'h0, "R10 div");
    drive(6'd58, 32'd9, 32'd3, 16'h3, "R10 modiu");
    drive(6'd7, 32'd9, 32'd3, 16'h3, "R10 undefined 7");
    drive(6'd45, 32'd9, 32'd3, 16'h3, "R10 undefined 45");
    // sweep all opcodes with several operand patterns
    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 64; o++) begin
        logic [31:0] va;
        logic [31:0] vb;
        logic [15:0] vi;
        string t;
        case (p)
          0: begin va = 32'h1357_9BDF; vb = 32'h0000_0003; vi = 16'h0005; end
          1: begin va = 32'hF00D_BEEF; vb = 32'hFFFF_FFF9; vi = 16'hFFF9; end
          2: begin va = 32'h0000_0004; vb = 32'h8000_0000; vi = 16'h8000; end
          default: begin va = 32'h7FFF_FFFF; vb = 32'h0000_0021; vi = 16'h0021; end
        endcase
        if (o < 16) t = "R1 sweep";
        else if (o < 32) t = "R2 sweep";
        else if (o == 39 || o >= 54) t = "R3 sweep";
        else t = "R10 sweep";
        drive(6'(o), va, vb, vi, t);
      end
    end
    @(posedge clk);
    @(posedge clk);
    drv_done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule